// File: doc/BRIEF.md
# Flash Operation Control and Block Lock Registers

This block is the software-visible register front end of an embedded flash controller. It decodes 32-bit bus writes with a write strobe into two registers. The first is an operation control register with five bits: erase select, program select, high-voltage enable, erase suspend and program suspend. The second is a block-lock register that protects groups of flash blocks from program and erase.

A single write can try to change several control bits at once. The block settles this with a fixed priority. The bits fall into four levels. Only the changes at the most urgent level that the write touches are applied, and every other requested change is dropped. Clearing a bit counts as a change in the same way as setting one.

The lock fields do not have fixed reset values. They load from a shadow-configuration input while reset is asserted. The block drives the effective per-block lock: each block is locked when either its register bit or the matching bit of a secondary lock vector is set. Reads return register contents combinationally. Writes take effect at the next rising clock edge.

Top module: `flash_ctl_regs`

## Requirements
- R1: While `rst_n` is low at a rising edge, the control register clears to 0, the lock enable clears to 0, and each lock field loads the same-position bit of `shadow_cfg`.
- R2: A write to offset 0x0 that changes bits at only one priority level updates the control register at the next rising edge. Control bit positions: bit 0 erase select, bit 1 program select, bit 2 high-voltage enable, bit 3 erase suspend, bit 4 program suspend.
- R3: Priority levels are erase select (1), program select (2), high-voltage enable (3), and both suspend bits (4). When a write changes bits at more than one level, only the changes at the lowest-numbered level take effect. For example, setting erase and program select together from zero sets only erase select.
- R4: Clearing a bit is a change request. A write that clears high-voltage enable and sets program suspend clears the enable and leaves program suspend unchanged.
- R5: Both suspend bits share level 4. A write that changes both, with no higher-level change, applies both changes.
- R6: The lock enable is bit 31 of the lock register at offset 0x4. It may be written at any time.
- R7: The lock fields are bit 20 (shadow lock), bits 17:16 (mid locks) and bits 9:0 (low locks). They are written only when the lock enable already held before the write is 1; otherwise they keep their value.
- R8: All other lock-register bits read 0 and ignore writes.
- R9: `block_lock` is {shadow lock, mid[1:0], low[9:0]} from the lock register, ORed bitwise with `sec_lock`.
- R10: An all-ones `shadow_cfg` during reset makes every lock field 1 (register value 0x001303FF).
- R11: `bus_rdata` reflects the addressed register in the same cycle. Addresses other than 0x0 and 0x4 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| shadow_cfg | input | 32 | Reset values of the lock fields, in register layout |
| sec_lock | input | 13 | Secondary lock vector, same order as `block_lock` |
| block_lock | output | 13 | Effective per-block lock |
| ctl_bits | output | 5 | Current control register, to the flash sequencer |

## Verification
A write strobed before a rising edge is visible on `bus_rdata`, `ctl_bits` and `block_lock` right after that edge, one register stage later. The driver therefore applies a write on one falling edge and removes it on the next. It only queues the expected read after that second falling edge. Reads and the OR with `sec_lock` are combinational, so the monitor compares one nanosecond after the address or `sec_lock` changes, well before the next rising edge. Reset values are compared after `rst_n` is released, with no write in between.

// File: rtl/flash_ctl_pkg.sv
// Package: shared widths, control bit positions, priority level masks and
// lock register field layout for the flash control register block.
package flash_ctl_pkg;

    localparam int CTL_W   = 5;
    localparam int N_LVL   = 4;
    localparam int N_LOW   = 10;
    localparam int N_MID   = 2;
    localparam int BLK_W   = 1 + N_MID + N_LOW;
    localparam int DATA_W  = 32;

    // Control bit positions (LSB numbering)
    localparam int C_ERASE = 0;
    localparam int C_PROG  = 1;
    localparam int C_HVEN  = 2;
    localparam int C_ESUSP = 3;
    localparam int C_PSUSP = 4;

    // Lock register positions (LSB numbering)
    localparam int L_EN    = 31;
    localparam int L_SHAD  = 20;
    localparam int L_MID   = 16;
    localparam int L_LOW   = 0;

    // Bits of the control register that belong to a priority level (0 = most urgent)
    function automatic logic [CTL_W-1:0] lvl_mask(input int lvl);
        logic [CTL_W-1:0] m;
        m = '0;
        case (lvl)
            0:       m[C_ERASE] = 1'b1;
            1:       m[C_PROG]  = 1'b1;
            2:       m[C_HVEN]  = 1'b1;
            default: begin
                m[C_ESUSP] = 1'b1;
                m[C_PSUSP] = 1'b1;
            end
        endcase
        return m;
    endfunction

    // Writable lock field bits, lock enable excluded
    function automatic logic [DATA_W-1:0] field_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[L_SHAD] = 1'b1;
        m[L_MID +: N_MID] = '1;
        m[L_LOW +: N_LOW] = '1;
        return m;
    endfunction

    // Gather the lock fields into the per-block vector
    function automatic logic [BLK_W-1:0] pack_blocks(input logic [DATA_W-1:0] r);
        return {r[L_SHAD], r[L_MID +: N_MID], r[L_LOW +: N_LOW]};
    endfunction

endpackage

// File: rtl/flash_ctl_arb.sv
// Control write arbiter: given the current control bits and a write value,
// finds the most urgent priority level that the write would change and
// returns the next register value with only that level's changes applied.
// Assumes: purely combinational, wr_en qualifies the write.
module flash_ctl_arb
    import flash_ctl_pkg::*;
(
    input  logic [CTL_W-1:0] cur,
    input  logic [CTL_W-1:0] wval,
    input  logic             wr_en,
    output logic [CTL_W-1:0] nxt
);

    logic [CTL_W-1:0] chg;
    logic [N_LVL-1:0] lvl_hit;
    logic [CTL_W-1:0] win_mask;

    // Bits the write asks to flip, set or clear alike
    always_comb chg = wr_en ? (cur ^ wval) : '0;

    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
        assign lvl_hit[l] = |(chg & lvl_mask(l));
    end

    // Select the lowest-numbered level with a pending change
    always_comb begin
        win_mask = '0;
        for (int l = N_LVL - 1; l >= 0; l--) begin
            if (lvl_hit[l]) win_mask = lvl_mask(l);
        end
    end

    // Apply only the winning level's flips
    always_comb nxt = cur ^ (chg & win_mask);

endmodule

// File: rtl/flash_ctl_bits.sv
// Control register: holds the five operation control bits and loads the
// arbitrated next value each cycle. Assumes synchronous active-low reset.
module flash_ctl_bits
    import flash_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wval,
    output logic [CTL_W-1:0] ctl_q
);

    logic [CTL_W-1:0] ctl_nxt;

    flash_ctl_arb i_arb (
        .cur   (ctl_q),
        .wval  (wval),
        .wr_en (wr_en),
        .nxt   (ctl_nxt)
    );

    // Register the arbitrated control value
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_nxt;
    end

endmodule

// File: rtl/flash_lock_reg.sv
// Block-lock register: the lock enable is always writable; lock fields load
// from shadow_cfg in reset and take writes only while the enable already
// held is 1. Reserved bits stay 0. Assumes synchronous active-low reset.
module flash_lock_reg
    import flash_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wval,
    input  logic [DATA_W-1:0] shadow_cfg,
    output logic [DATA_W-1:0] lock_q
);

    localparam logic [DATA_W-1:0] FMASK = field_mask();

    logic [DATA_W-1:0] lock_nxt;

    // Next value: enable always, fields only when currently enabled
    always_comb begin
        lock_nxt = lock_q;
        if (wr_en) begin
            lock_nxt[L_EN] = wval[L_EN];
            if (lock_q[L_EN]) lock_nxt = (lock_nxt & ~FMASK) | (wval & FMASK);
        end
    end

    // Register with shadow-derived reset of the fields
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= shadow_cfg & FMASK;
        else        lock_q <= lock_nxt;
    end

endmodule

// File: rtl/flash_ctl_regs.sv
// Top: decodes bus writes to the control and lock registers, returns
// combinational read data, and drives the effective block lock as the OR
// of the lock fields and the secondary lock vector.
module flash_ctl_regs
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CTL_OFFS  = 0,
    parameter int LOCK_OFFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       shadow_cfg,
    input  logic [12:0]       sec_lock,
    output logic [12:0]       block_lock,
    output logic [4:0]        ctl_bits
);

    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_OFFS);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_OFFS);

    logic              sel_ctl;
    logic              sel_lock;
    logic [CTL_W-1:0]  ctl_q;
    logic [DATA_W-1:0] lock_q;

    // Address decode
    always_comb begin
        sel_ctl  = (bus_addr == A_CTL);
        sel_lock = (bus_addr == A_LOCK);
    end

    flash_ctl_bits i_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we && sel_ctl),
        .wval  (bus_wdata[CTL_W-1:0]),
        .ctl_q (ctl_q)
    );

    flash_lock_reg i_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_we && sel_lock),
        .wval       (bus_wdata),
        .shadow_cfg (shadow_cfg),
        .lock_q     (lock_q)
    );

    // Read mux, unmapped offsets read zero
    always_comb begin
        bus_rdata = '0;
        if (sel_ctl)       bus_rdata[CTL_W-1:0] = ctl_q;
        else if (sel_lock) bus_rdata = lock_q;
    end

    // Effective lock and control outputs
    always_comb begin
        block_lock = pack_blocks(lock_q) | sec_lock;
        ctl_bits   = ctl_q;
    end

endmodule

// File: rtl/flash_ctl_regs_chk.sv
// Checker for flash_ctl_regs: priority outcome, lock write gating, reserved
// bits and the lock OR. Attached through bind below.
module flash_ctl_regs_chk
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LOCK_OFFS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [12:0]       sec_lock,
    input logic [12:0]       block_lock,
    input logic [CTL_W-1:0]  ctl_q,
    input logic [31:0]       lock_q
);

    localparam logic [31:0] FMASK = field_mask();

    logic             past_ok;
    logic [N_LVL-1:0] lvl_chg;
    logic [CTL_W-1:0] ctl_prev;

    // One cycle of history after reset before past-based checks
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
        ctl_prev <= ctl_q;
    end

    for (genvar l = 0; l < N_LVL; l++) begin : g_chg
        assign lvl_chg[l] = |((ctl_q ^ ctl_prev) & lvl_mask(l));
    end

    // R3: an update never touches more than one level
    p_one_level_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $onehot0(lvl_chg));

    // R2: control bits hold without a write
    p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(bus_we) |-> $stable(ctl_q));

    // R7: fields hold when a lock write arrives with enable 0
    p_lock_gate_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(bus_we) && $past(bus_addr) == ADDR_W'(LOCK_OFFS) && !$past(lock_q[L_EN]))
        |-> ((lock_q & FMASK) == ($past(lock_q) & FMASK)));

    // R8: reserved bits read zero
    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(LOCK_OFFS)) |-> ((bus_rdata & ~FMASK & ~(32'h1 << L_EN)) == '0));

    // R9: a secondary lock always locks the block
    p_sec_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (block_lock & sec_lock) == sec_lock);

endmodule

bind flash_ctl_regs flash_ctl_regs_chk #(.ADDR_W(ADDR_W), .LOCK_OFFS(LOCK_OFFS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .sec_lock   (sec_lock),
    .block_lock (block_lock),
    .ctl_q      (ctl_q),
    .lock_q     (lock_q)
);

// File: tb/test_flash_ctl_regs.sv
module test_flash_ctl_regs;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp_rd;
        logic [12:0] exp_blk;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] shadow_cfg = 32'hFFFF_FFFF;
    logic [12:0] sec_lock = '0;
    logic [12:0] block_lock;
    logic [4:0]  ctl_bits;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    flash_ctl_regs i_flash_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .shadow_cfg(shadow_cfg),
        .sec_lock(sec_lock), .block_lock(block_lock), .ctl_bits(ctl_bits)
    );

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    // Driver: present address, queue expected read and lock
    task automatic expect_rd(input logic [7:0] a, input logic [31:0] rd,
                             input logic [12:0] blk, input string tag);
        item_t it;
        bus_addr = a;
        it.addr = a; it.exp_rd = rd; it.exp_blk = blk; it.tag = tag;
        q.push_back(it);
        #2;
    endtask

    // Monitor: compare each queued item 1 ns after it is queued
    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            #1;
            it = q.pop_front();
            n_chk++;
            if (bus_rdata !== it.exp_rd || block_lock !== it.exp_blk) begin
                n_err++;
                $display("FAIL %s addr=%h rdata=%h exp=%h block_lock=%h exp=%h",
                         it.tag, it.addr, bus_rdata, it.exp_rd, block_lock, it.exp_blk);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 R10: erased shadow
        do_reset();
        @(negedge clk);
        expect_rd(8'h00, 32'h0, 13'h1FFF, "R1 ctl reset");
        expect_rd(8'h04, 32'h0013_03FF, 13'h1FFF, "R10 erased shadow");
        // R1 R9: partial shadow
        shadow_cfg = 32'h0001_0155;
        do_reset();
        @(negedge clk);
        expect_rd(8'h04, 32'h0001_0155, 13'h0555, "R1 shadow load");
        sec_lock = 13'h1002;
        expect_rd(8'h04, 32'h0001_0155, 13'h1557, "R9 or secondary");
        sec_lock = 13'h0000;
        // R2
        wr(8'h00, 32'h04);
        expect_rd(8'h00, 32'h04, 13'h0555, "R2 single level");
        // R3: erase+program from hv set
        wr(8'h00, 32'h03);
        expect_rd(8'h00, 32'h05, 13'h0555, "R3 erase wins");
        wr(8'h00, 32'h18);
        expect_rd(8'h00, 32'h04, 13'h0555, "R3 clear erase wins");
        // R4
        wr(8'h00, 32'h10);
        expect_rd(8'h00, 32'h00, 13'h0555, "R4 hv clear wins");
        // R5
        wr(8'h00, 32'h18);
        expect_rd(8'h00, 32'h18, 13'h0555, "R5 both suspends");
        wr(8'h00, 32'h08);
        expect_rd(8'h00, 32'h08, 13'h0555, "R5 one suspend clear");
        // R11: unmapped write and read
        wr(8'h08, 32'hFFFF_FFFF);
        expect_rd(8'h08, 32'h0, 13'h0555, "R11 unmapped reads 0");
        expect_rd(8'h00, 32'h08, 13'h0555, "R11 ctl untouched");
        // R6 R7 R8: enable off, fields ignored, enable set
        wr(8'h04, 32'hFFFF_FFFF);
        expect_rd(8'h04, 32'h8001_0155, 13'h0555, "R7 fields gated R6 enable set");
        wr(8'h04, 32'h8000_0000);
        expect_rd(8'h04, 32'h8000_0000, 13'h0000, "R7 fields written");
        wr(8'h04, 32'h7FFF_FFFF);
        expect_rd(8'h04, 32'h0013_03FF, 13'h1FFF, "R6 enable clear R8 reserved");
        wr(8'h04, 32'h0000_0000);
        expect_rd(8'h04, 32'h0013_03FF, 13'h1FFF, "R7 ignored when disabled");
        expect_rd(8'h00, 32'h08, 13'h1FFF, "R11 ctl after lock writes");
        wait (q.size() == 0);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule